// File: doc/BRIEF.md
# User Scan Chain Hub

The hub sits between a JTAG TAP controller and two scan registers defined by the surrounding design. It watches the current instruction and the TAP state, both supplied by the TAP controller. When the instruction holds one of two user codes, the hub raises the select line for that chain. It also gives that chain a private data clock, which runs only while the TAP is capturing or shifting a data register. During a data-register shift, the hub returns that chain's serial output on TDO.

Both chains take their serial input from one shared line driven from TDI. Both also see three shared status flags, which report whether the TAP is in test-logic-reset, shift-DR or update-DR. A user register clocked by its private clock loads parallel data when the shift flag is low and shifts when it is high. TDO is retimed to the falling TCK edge. Its output enable is low whenever the hub is not returning user data.

Top module: `user_scan_hub`

## Requirements
- R1: `sel_o[0]` is high exactly when `ir_i` equals USER1_CODE (default 5'h02). `sel_o[1]` is high exactly when `ir_i` equals USER2_CODE (default 5'h03). The two selects are never high together.
- R2: `tdi_o` follows `tdi_i` and is the only serial input for both chains. After a full scan, the selected chain holds the bits presented on `tdi_i`.
- R3: A TCK cycle has state CAPTURE_DR (4'h6) or SHIFT_DR (4'h2) while `sel_o[i]` is high. For each such cycle, `drck_o[i]` gives exactly one high pulse, and it coincides with the TCK rising edge that ends that cycle. A scan of L bits therefore gives 1+L pulses.
- R4: `drck_o[i]` stays low in every other cycle. This includes SHIFT_IR (4'hA) with a user code still loaded, PAUSE_DR (4'h3) and the exit states. The unselected chain keeps its contents through the other chain's scan.
- R5: `reset_o`, `shift_o` and `update_o` are high exactly while `state_i` is TEST_LOGIC_RESET (4'hF), SHIFT_DR (4'h2) and UPDATE_DR (4'h5) respectively.
- R6: On each falling TCK edge in SHIFT_DR with a user code active, `tdo_o` takes the selected chain's return bit. The bits come out least significant first, starting with the captured value.
- R7: `tdo_oe_o` is high only in cycles whose state at the falling edge is SHIFT_DR with a user code active. It is low in PAUSE_DR and every other state.
- R8: With no user code in `ir_i`, the hub gives no `drck_o` pulses and keeps `tdo_oe_o` low through a complete DR scan.
- R9: While `rst_ni` is low, `drck_o` is 0, `tdo_oe_o` is 0 and `tdo_o` is 0, whatever `state_i` and `ir_i` hold. This applies even when reset is asserted in the middle of a shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| state_i | input | 4 | Current TAP state code |
| ir_i | input | IR_W | Current instruction |
| tdi_i | input | 1 | Serial data from the TAP input pin |
| user_tdo_i | input | 2 | Serial return bit of each user chain |
| sel_o | output | 2 | Per-chain instruction select |
| drck_o | output | 2 | Per-chain gated data clock |
| tdi_o | output | 1 | Shared serial input to both chains |
| reset_o | output | 1 | TAP is in test-logic-reset |
| shift_o | output | 1 | TAP is in shift-DR |
| update_o | output | 1 | TAP is in update-DR |
| tdo_o | output | 1 | Retimed serial output |
| tdo_oe_o | output | 1 | Output enable for TDO |

## Verification
The hardest case to reach from the ports is a user data scan that is split by PAUSE_DR. In that case the gated clock must stop and the output enable must drop, and both must resume without losing or repeating a bit. A second hard case is an IR scan that runs while a user code is still loaded from the previous scan. The bench reaches both by walking the TAP state sequence itself, holding PAUSE_DR for two cycles part way through a 12-bit USER2 scan and loading each instruction directly after a user scan. A scoreboard queue then proves that the bit order is unbroken, and pulse counters prove that no extra clocks occur.

// File: rtl/user_scan_pkg.sv
package user_scan_pkg;
  localparam int NUM_CHAINS = 2;
  localparam int STATE_W    = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_EXIT2_DR  = 4'h0,
    ST_EXIT1_DR  = 4'h1,
    ST_SHIFT_DR  = 4'h2,
    ST_PAUSE_DR  = 4'h3,
    ST_SEL_IR    = 4'h4,
    ST_UPDATE_DR = 4'h5,
    ST_CAP_DR    = 4'h6,
    ST_SEL_DR    = 4'h7,
    ST_EXIT2_IR  = 4'h8,
    ST_EXIT1_IR  = 4'h9,
    ST_SHIFT_IR  = 4'hA,
    ST_PAUSE_IR  = 4'hB,
    ST_IDLE      = 4'hC,
    ST_UPDATE_IR = 4'hD,
    ST_CAP_IR    = 4'hE,
    ST_TLR       = 4'hF
  } tap_state_e;
endpackage

// File: rtl/usr_state_decode.sv
module usr_state_decode
  import user_scan_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic               reset_o,
  output logic               capture_dr_o,
  output logic               shift_dr_o,
  output logic               update_dr_o
);
  tap_state_e st;

  always_comb begin
    st           = tap_state_e'(state_i);
    reset_o      = (st == ST_TLR);
    capture_dr_o = (st == ST_CAP_DR);
    shift_dr_o   = (st == ST_SHIFT_DR);
    update_dr_o  = (st == ST_UPDATE_DR);
  end
endmodule

// File: rtl/usr_chain_port.sv
module usr_chain_port #(
  parameter int              IR_W = 5,
  parameter logic [IR_W-1:0] CODE = '0
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic [IR_W-1:0] ir_i,
  input  logic            dr_active_i,
  output logic            sel_o,
  output logic            drck_o
);
  logic clk_en_q;

  assign sel_o = (ir_i == CODE);

  // enable changes only while tck is low, so the gated clock cannot glitch
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) clk_en_q <= 1'b0;
    else         clk_en_q <= sel_o & dr_active_i;
  end

  assign drck_o = tck_i & clk_en_q;
endmodule

// File: rtl/usr_tdo_mux.sv
module usr_tdo_mux #(
  parameter int NUM = 2
) (
  input  logic           tck_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] sel_i,
  input  logic [NUM-1:0] chain_tdo_i,
  input  logic           shift_dr_i,
  output logic           tdo_o,
  output logic           tdo_oe_o
);
  logic pick;
  logic drive;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      if (sel_i[i]) pick = chain_tdo_i[i];
    end
  end

  assign drive = shift_dr_i & (|sel_i);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_oe_o <= drive;
      if (drive) tdo_o <= pick;
    end
  end
endmodule

// File: rtl/user_scan_hub.sv
module user_scan_hub
  import user_scan_pkg::*;
#(
  parameter int              IR_W       = 5,
  parameter logic [IR_W-1:0] USER1_CODE = 5'h02,
  parameter logic [IR_W-1:0] USER2_CODE = 5'h03
) (
  input  logic                  tck_i,
  input  logic                  rst_ni,
  input  logic [STATE_W-1:0]    state_i,
  input  logic [IR_W-1:0]       ir_i,
  input  logic                  tdi_i,
  input  logic [NUM_CHAINS-1:0] user_tdo_i,
  output logic [NUM_CHAINS-1:0] sel_o,
  output logic [NUM_CHAINS-1:0] drck_o,
  output logic                  tdi_o,
  output logic                  reset_o,
  output logic                  shift_o,
  output logic                  update_o,
  output logic                  tdo_o,
  output logic                  tdo_oe_o
);
  localparam logic [NUM_CHAINS*IR_W-1:0] CODES = {USER2_CODE, USER1_CODE};

  logic capture_dr;
  logic dr_active;

  usr_state_decode i_decode (
    .state_i      (state_i),
    .reset_o      (reset_o),
    .capture_dr_o (capture_dr),
    .shift_dr_o   (shift_o),
    .update_dr_o  (update_o)
  );

  assign dr_active = capture_dr | shift_o;
  assign tdi_o     = tdi_i;

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
    usr_chain_port #(
      .IR_W (IR_W),
      .CODE (CODES[g*IR_W +: IR_W])
    ) i_port (
      .tck_i       (tck_i),
      .rst_ni      (rst_ni),
      .ir_i        (ir_i),
      .dr_active_i (dr_active),
      .sel_o       (sel_o[g]),
      .drck_o      (drck_o[g])
    );
  end

  usr_tdo_mux #(.NUM(NUM_CHAINS)) i_tdo (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_o),
    .chain_tdo_i (user_tdo_i),
    .shift_dr_i  (shift_o),
    .tdo_o       (tdo_o),
    .tdo_oe_o    (tdo_oe_o)
  );
endmodule

// File: rtl/user_scan_hub_chk.sv
module user_scan_hub_chk #(
  parameter int NUM = 2
) (
  input logic           tck_i,
  input logic           rst_ni,
  input logic [NUM-1:0] sel_o,
  input logic [NUM-1:0] drck_o,
  input logic           reset_o,
  input logic           shift_o,
  input logic           update_o,
  input logic           tdo_oe_o
);
  p_sel_excl_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  p_flags_excl_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({reset_o, shift_o, update_o}));

  p_oe_in_shift_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> shift_o);

  p_oe_needs_user_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (sel_o != '0));

  for (genvar g = 0; g < NUM; g++) begin : g_drck
    p_drck_sel_r3: assert property (@(negedge tck_i) disable iff (!rst_ni)
      drck_o[g] |-> sel_o[g]);
  end
endmodule

bind user_scan_hub user_scan_hub_chk #(.NUM(user_scan_pkg::NUM_CHAINS)) i_chk (
  .tck_i    (tck_i),
  .rst_ni   (rst_ni),
  .sel_o    (sel_o),
  .drck_o   (drck_o),
  .reset_o  (reset_o),
  .shift_o  (shift_o),
  .update_o (update_o),
  .tdo_oe_o (tdo_oe_o)
);

// File: tb/test_user_scan_hub.sv
module test_user_scan_hub;
  localparam int TCK_PERIOD = 20;
  localparam logic [4:0] U1 = 5'h02;
  localparam logic [4:0] U2 = 5'h03;
  localparam logic [4:0] BYP = 5'h1F;
  localparam logic [7:0]  CAP0 = 8'hA5;
  localparam logic [11:0] CAP1 = 12'h3C9;

  logic       tck = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] state_i = 4'hF;
  logic [4:0] ir_i = BYP;
  logic       tdi_i = 1'b0;
  logic [1:0] user_tdo;
  logic [1:0] sel_o, drck_o;
  logic       tdi_o, reset_o, shift_o, update_o, tdo_o, tdo_oe_o;

  int checks = 0;
  int errors = 0;
  int cnt0 = 0;
  int cnt1 = 0;
  bit mon_en = 1'b0;
  logic exp_q[$];

  logic [7:0]  ch0 = 8'h00;
  logic [11:0] ch1 = 12'h000;

  always #(TCK_PERIOD/2) tck = ~tck;

  user_scan_hub i_user_scan_hub (
    .tck_i(tck), .rst_ni(rst_ni), .state_i(state_i), .ir_i(ir_i),
    .tdi_i(tdi_i), .user_tdo_i(user_tdo), .sel_o(sel_o), .drck_o(drck_o),
    .tdi_o(tdi_o), .reset_o(reset_o), .shift_o(shift_o), .update_o(update_o),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o)
  );

  // example user registers
  always_ff @(posedge drck_o[0]) ch0 <= shift_o ? {tdi_o, ch0[7:1]} : CAP0;
  always_ff @(posedge drck_o[1]) ch1 <= shift_o ? {tdi_o, ch1[11:1]} : CAP1;
  assign user_tdo = {ch1[0], ch0[0]};

  always @(posedge drck_o[0]) cnt0++;
  always @(posedge drck_o[1]) cnt1++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for TDO and enable
  initial forever begin
    @(negedge tck);
    #(TCK_PERIOD/4);
    if (mon_en) begin
      logic exp_oe;
      exp_oe = (state_i == 4'h2) && (ir_i == U1 || ir_i == U2);
      chk("R7 tdo_oe", tdo_oe_o, exp_oe);
      if (exp_oe) begin
        if (exp_q.size() == 0) chk("R6 unexpected tdo bit", 1, 0);
        else chk("R6 tdo bit", tdo_o, exp_q.pop_front());
      end
    end
  end

  task automatic drive(logic [3:0] st, logic d = 1'b0);
    @(posedge tck);
    #1;
    state_i = st;
    tdi_i   = d;
  endtask

  task automatic load_ir(logic [4:0] code);
    int c0, c1;
    c0 = cnt0; c1 = cnt1;
    drive(4'h7); drive(4'h4); drive(4'hE);
    repeat (5) drive(4'hA);
    drive(4'h9); drive(4'hD);
    drive(4'hC);
    ir_i = code;
    drive(4'hC);
    chk("R4 no drck during IR scan ch0", cnt0 - c0, 0);
    chk("R4 no drck during IR scan ch1", cnt1 - c1, 0);
  endtask

  task automatic dr_scan(int user, int width, logic [15:0] cap,
                         logic [15:0] data, int pause_at);
    drive(4'h7);
    drive(4'h6);
    for (int k = 0; k < width; k++) begin
      if (k == pause_at) begin
        drive(4'h1); drive(4'h3); drive(4'h3); drive(4'h0);
      end
      if (user >= 0) exp_q.push_back(cap[k]);
      drive(4'h2, data[k]);
    end
    drive(4'h1); drive(4'h5); drive(4'hC); drive(4'hC);
  endtask

  initial begin
    #(TCK_PERIOD*100000);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0, c1;
    // reset held with a user code in capture state
    state_i = 4'h6; ir_i = U1;
    repeat (3) @(posedge tck);
    #2;
    chk("R9 drck in reset", drck_o, 2'b00);
    chk("R9 oe in reset", tdo_oe_o, 0);
    chk("R9 tdo in reset", tdo_o, 0);
    state_i = 4'hF; ir_i = BYP;
    #1;
    chk("R5 reset flag in TLR", reset_o, 1);
    @(negedge tck); #3;
    rst_ni = 1'b1;
    mon_en = 1'b1;

    // state decode sweep
    for (int s = 0; s < 16; s++) begin
      drive(s[3:0]);
      @(negedge tck); #1;
      chk("R5 reset_o", reset_o, s == 15);
      chk("R5 shift_o", shift_o, s == 2);
      chk("R5 update_o", update_o, s == 5);
    end
    drive(4'hC);

    // USER1 scan, 8 bits
    load_ir(U1);
    chk("R1 sel USER1", sel_o, 2'b01);
    c0 = cnt0; c1 = cnt1;
    dr_scan(0, 8, {8'h0, CAP0}, 16'h003C, -1);
    chk("R3 ch0 pulses", cnt0 - c0, 9);
    chk("R4 ch1 idle pulses", cnt1 - c1, 0);
    chk("R2 ch0 contents", ch0, 8'h3C);
    chk("R4 ch1 untouched", ch1, 12'h000);

    // USER2 scan, 12 bits, paused after 5
    load_ir(U2);
    chk("R1 sel USER2", sel_o, 2'b10);
    c0 = cnt0; c1 = cnt1;
    dr_scan(1, 12, {4'h0, CAP1}, 16'h0B61, 5);
    chk("R3 ch1 pulses with pause", cnt1 - c1, 13);
    chk("R4 ch0 idle pulses", cnt0 - c0, 0);
    chk("R2 ch1 contents", ch1, 12'hB61);
    chk("R4 ch0 untouched", ch0, 8'h3C);

    // no user instruction
    load_ir(BYP);
    chk("R1 sel none", sel_o, 2'b00);
    c0 = cnt0; c1 = cnt1;
    dr_scan(-1, 8, 16'h0, 16'h00FF, -1);
    chk("R8 ch0 pulses", cnt0 - c0, 0);
    chk("R8 ch1 pulses", cnt1 - c1, 0);
    chk("R8 ch0 untouched", ch0, 8'h3C);
    chk("R8 ch1 untouched", ch1, 12'hB61);
    chk("R6 queue drained", exp_q.size(), 0);

    // reset in the middle of a user shift
    load_ir(U1);
    mon_en = 1'b0;
    drive(4'h7); drive(4'h6); drive(4'h2);
    @(negedge tck); #2;
    chk("R7 oe in shift", tdo_oe_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R9 oe after async reset", tdo_oe_o, 0);
    chk("R9 tdo after async reset", tdo_o, 0);
    @(posedge tck); #2;
    chk("R9 drck after async reset", drck_o, 2'b00);
    state_i = 4'hF;
    @(negedge tck); #3;
    rst_ni = 1'b1;
    drive(4'hC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule